// File: doc/BRIEF.md
# Pipelined Split-Squaring Mixing Unit

This block computes the non-linear mixing function used by a counter-assisted stream-cipher core. It adds a 32-bit state word and a 32-bit counter word modulo 2^32 and squares the sum to 64 bits. The result is the upper 32 bits of the square XORed with the lower 32 bits. The square is not taken from one wide multiplier. It is rebuilt from three half-width (16x16) products: low times low, high times high, and one cross product. Each product is placed at a fixed shift offset and the three are summed.

The unit is a three-stage pipeline: the add, then the three products, then the summation and fold. It accepts a new operand pair on every clock. This makes it suitable for C-slow or interleaved cores, where a different independent stream enters on each cycle. A valid flag and a small stream tag travel with each operand pair. They leave the unit three cycles later together with the matching result. A cycle with valid low is a bubble. It moves through the pipeline like any other slot and does not disturb the operations ahead of it or behind it.

Top module: `mix_square_pipe`

## Requirements
- R1: While reset is held, and on the first sampling after reset, `out_valid` is 0.
- R2: The sum u = `in_x` + `in_c` wraps modulo 2^32. For example, 0xF0000000 + 0x20000000 gives u = 0x10000000, and the result is that of u alone.
- R3: `out_g` equals the low 32 bits of u*u (the exact 64-bit square) XOR the high 32 bits of u*u.
- R4: An input accepted with `in_valid` = 1 at a rising edge appears with `out_valid` = 1 after exactly three rising edges.
- R5: `out_tag` equals the `in_tag` that was presented together with the operand pair whose result is on `out_g`.
- R6: A new operand pair is accepted on every cycle. Back-to-back inputs from different streams produce back-to-back results in input order.
- R7: An input cycle with `in_valid` = 0 gives `out_valid` = 0 three cycles later, and the results of the valid neighbours are unchanged.
- R8: Corner values: u = 0 gives 0x00000000, u = 0xFFFFFFFF gives 0xFFFFFFFF, and u = 0x00010000 gives 0x00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset; clears the valid pipeline |
| in_valid | input | 1 | Operand pair present this cycle |
| in_tag | input | TAG_W (2) | Stream identifier carried with the operands |
| in_x | input | W (32) | State word |
| in_c | input | W (32) | Counter word |
| out_valid | output | 1 | Result present this cycle |
| out_tag | output | TAG_W (2) | Stream identifier of the result |
| out_g | output | W (32) | Folded square of the sum |

## Verification
The assertions assume that reset is held for at least one rising edge before any operand is offered. The latency properties also assume that reset is not asserted again while results are still in flight. The bench raises reset once, before its first scenario. After that it keeps reset inactive and lets every sequence drain before the next one starts. The data path is driven on every cycle, bubbles included, so the fold assertion sees real values even in slots that carry no valid operand.

// File: rtl/mix_square_pipe.sv
module mix_square_pipe #(
  parameter int W     = 32,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [W-1:0]     in_x,
  input  logic [W-1:0]     in_c,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag,
  output logic [W-1:0]     out_g
);
  localparam int HALF = W / 2;
  localparam int SQW  = 2 * W;

  // stage 1: sum
  logic             s1_v, s2_v;
  logic [TAG_W-1:0] s1_tag, s2_tag;
  logic [W-1:0]     s1_u;

  // stage 2: half-width products
  logic [W-1:0] p_ll, p_hh, p_lh;
  logic [W-1:0] s2_ll, s2_hh, s2_lh;
  logic [SQW-1:0] sq;

  wire [HALF-1:0] u_lo = s1_u[HALF-1:0];
  wire [HALF-1:0] u_hi = s1_u[W-1:HALF];

  assign p_ll = {{HALF{1'b0}}, u_lo} * {{HALF{1'b0}}, u_lo};
  assign p_hh = {{HALF{1'b0}}, u_hi} * {{HALF{1'b0}}, u_hi};
  assign p_lh = {{HALF{1'b0}}, u_lo} * {{HALF{1'b0}}, u_hi};

  // stage 3: place products and fold
  assign sq = {s2_hh, {W{1'b0}}}
            + ({{W{1'b0}}, s2_lh} << (HALF + 1))
            + {{W{1'b0}}, s2_ll};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_v      <= in_valid;
      s2_v      <= s1_v;
      out_valid <= s2_v;
    end
  end

  always_ff @(posedge clk) begin
    s1_tag  <= in_tag;
    s1_u    <= in_x + in_c;
    s2_tag  <= s1_tag;
    s2_ll   <= p_ll;
    s2_hh   <= p_hh;
    s2_lh   <= p_lh;
    out_tag <= s2_tag;
    out_g   <= sq[W-1:0] ^ sq[SQW-1:W];
  end

  function automatic logic [W-1:0] fold_direct(input logic [W-1:0] u);
    logic [SQW-1:0] f;
    f = {{W{1'b0}}, u} * {{W{1'b0}}, u};
    return f[W-1:0] ^ f[SQW-1:W];
  endfunction

  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> !out_valid);

  a_r3_fold_matches_square: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |-> ##2 (out_g == fold_direct($past(s1_u, 2))));

  a_r4_latency_three: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  a_r5_tag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 (out_tag == $past(in_tag, 3)));

  a_r7_bubble_passes: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);
endmodule

// File: tb/tb_mix_square_pipe.sv
module tb_mix_square_pipe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_tag = '0;
  logic [31:0] in_x = '0, in_c = '0;
  logic        out_valid;
  logic [1:0]  out_tag;
  logic [31:0] out_g;

  int tests = 0, fails = 0;

  logic [31:0] sx [16];
  logic [31:0] sc [16];
  logic        sv [16];
  logic [1:0]  st [16];

  always #10 clk = ~clk;

  mix_square_pipe dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
                       .in_x(in_x), .in_c(in_c), .out_valid(out_valid),
                       .out_tag(out_tag), .out_g(out_g));

  function automatic logic [31:0] ref_g(input logic [31:0] x, input logic [31:0] c);
    logic [31:0] u;
    logic [63:0] q;
    u = x + c;
    q = {32'd0, u} * {32'd0, u};
    return q[31:0] ^ q[63:32];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive n entries back to back at negedges, check each one three cycles later
  task automatic run_seq(input int n, input string req);
    for (int t = 0; t < n + 3; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        check({req, " R4 valid"}, {31'd0, out_valid}, {31'd0, sv[t-3]});
        if (sv[t-3]) begin
          check({req, " R5 tag"}, {30'd0, out_tag}, {30'd0, st[t-3]});
          check({req, " R3 value"}, out_g, ref_g(sx[t-3], sc[t-3]));
        end
      end
      if (t < n) begin
        in_valid = sv[t]; in_tag = st[t]; in_x = sx[t]; in_c = sc[t];
      end else begin
        in_valid = 1'b0; in_tag = '0; in_x = '0; in_c = '0;
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 valid during reset", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_corners;
    sx[0] = 32'h0;        sc[0] = 32'h0;      sv[0] = 1; st[0] = 2'd0;
    sx[1] = 32'hFFFFFFFF; sc[1] = 32'h0;      sv[1] = 1; st[1] = 2'd1;
    sx[2] = 32'h8000;     sc[2] = 32'h8000;   sv[2] = 1; st[2] = 2'd2;
    run_seq(3, "R8 corners");
    check("R8 u=0 fold", ref_g(32'h0, 32'h0), 32'h00000000);
    check("R8 u=FFFFFFFF fold", ref_g(32'hFFFFFFFF, 32'h0), 32'hFFFFFFFF);
    check("R8 u=10000 fold", ref_g(32'h8000, 32'h8000), 32'h00000001);
  endtask

  task automatic t_wrap;
    sx[0] = 32'hF0000000; sc[0] = 32'h20000000; sv[0] = 1; st[0] = 2'd3;
    sx[1] = 32'hFFFFFFFF; sc[1] = 32'h00000001; sv[1] = 1; st[1] = 2'd0;
    run_seq(2, "R2 wrap");
    check("R2 wrapped sum equals u alone", ref_g(32'hF0000000, 32'h20000000),
          ref_g(32'h10000000, 32'h0));
  endtask

  task automatic t_stream;
    logic [31:0] a = 32'h1234_5678;
    for (int i = 0; i < 12; i++) begin
      a = a * 32'd1103515245 + 32'd12345;
      sx[i] = a;
      sc[i] = {a[15:0], a[31:16]} ^ 32'h4D34D34D;
      sv[i] = 1'b1;
      st[i] = i[1:0];
    end
    run_seq(12, "R6 stream");
  endtask

  task automatic t_bubbles;
    for (int i = 0; i < 10; i++) begin
      sx[i] = 32'hA5A5_0000 + i * 32'h0101_3377;
      sc[i] = 32'h3C3C_1111 * (i + 1);
      sv[i] = (i % 3) != 1;
      st[i] = 2'(3 - i);
    end
    run_seq(10, "R7 bubbles");
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_wrap();
    t_stream();
    t_bubbles();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule